// File: doc/BRIEF.md
# Ethernet Transmit Deferral and Receive Gap Timer

This block decides when a half-duplex Ethernet transmitter may start its next frame. After each transmit-done or backoff-done pulse it waits for carrier sense to drop, then counts bit-time ticks through a 96 bit-time inter-packet gap. The gap has two parts. In the first 60 bit times, carrier activity aborts the count, and the block waits again for a quiet line. In the last 36 bit times, carrier is ignored, and the transmitter is released on schedule even if that leads to a collision.

On the receive side, the block measures the idle gap between received frames in the same bit-time ticks. A frame that starts fewer than 28 bit times after the previous one ended is marked with a one-cycle pulse, so that downstream logic can drop it.

All timing advances only on a single-cycle bit-time tick input. The same logic therefore serves any line rate, provided the tick is derived from that rate.

Top module: `deferral_timer`

## Requirements
- R1: After reset, `tx_ok` and `rx_short` are 0, and the block performs a full deferral before it first raises `tx_ok`.
- R2: A `tx_done` pulse drives `tx_ok` low from the next cycle and restarts deferral. While `crs` stays high afterwards, no tick is counted.
- R3: Counting begins one cycle after `crs` is sampled low. `tx_ok` rises in the cycle after the edge that samples the 96th counted tick (60 early plus 36 late).
- R4: If `crs` is sampled high while fewer than 60 ticks have been counted, the count is discarded. The block then waits for `crs` to be low and again needs a full 96 ticks.
- R5: If `crs` is high once 60 or more ticks have been counted, it has no effect, and `tx_ok` rises at the same tick as with a quiet line.
- R6: `tx_ok` stays high until `tx_start` is sampled high. It is then low from the next cycle and stays low, whatever the ticks and `crs` do, until a `tx_done` pulse has led to a new full deferral.
- R7: Cycles without `bit_tick` never advance either timer.
- R8: `rx_short` is a one-cycle pulse. It is high in the cycle after `rx_dv` is first sampled high, when fewer than 28 ticks were sampled with `rx_dv` low since the previous frame ended.
- R9: A frame that follows a gap of 28 or more ticks is not flagged, and neither is the first frame after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| crs | input | 1 | Carrier sense |
| tx_done | input | 1 | Pulse: transmission or backoff finished |
| tx_start | input | 1 | Pulse: transmitter begins a frame |
| rx_dv | input | 1 | Receive data valid |
| tx_ok | output | 1 | Transmit permitted |
| rx_short | output | 1 | Pulse: current receive frame followed too short a gap |

## Verification
Some rules are checked on every cycle by the assertions: `tx_ok` drops after `tx_start` or `tx_done`, it holds while neither arrives, and it only opens on a tick. They also check that `rx_short` is a single pulse that follows a rising edge of `rx_dv`. The exact tick counts cannot be seen at the ports cycle by cycle, so the bench's sweeps show them. These are the 96-tick release point, the abort at every early position, the carrier being ignored at every late position, and the 28-tick receive threshold.

// File: rtl/deferral_timer.sv
module deferral_timer #(
  parameter int EARLY_BT  = 60,
  parameter int LATE_BT   = 36,
  parameter int RX_GAP_BT = 28
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic crs,
  input  logic tx_done,
  input  logic tx_start,
  input  logic rx_dv,
  output logic tx_ok,
  output logic rx_short
);
  localparam int TMAX = (EARLY_BT > LATE_BT) ? EARLY_BT : LATE_BT;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int RW   = $clog2(RX_GAP_BT + 1);

  typedef enum logic [2:0] {S_WAIT, S_EARLY, S_LATE, S_OPEN, S_BUSY} st_t;

  st_t           state;
  logic [TW-1:0] cnt;
  logic          rx_dv_q, seen;
  logic [RW-1:0] gap;
  logic          rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_WAIT;
      cnt   <= '0;
    end else if (tx_done) begin
      state <= S_WAIT;
      cnt   <= '0;
    end else begin
      case (state)
        S_WAIT: if (!crs) begin
          state <= S_EARLY;
          cnt   <= '0;
        end
        S_EARLY: begin
          if (crs) state <= S_WAIT;
          else if (bit_tick) begin
            if (cnt == TW'(EARLY_BT - 1)) begin
              state <= S_LATE;
              cnt   <= '0;
            end else cnt <= cnt + 1'b1;
          end
        end
        S_LATE: if (bit_tick) begin
          if (cnt == TW'(LATE_BT - 1)) state <= S_OPEN;
          else cnt <= cnt + 1'b1;
        end
        S_OPEN: if (tx_start) state <= S_BUSY;
        S_BUSY: state <= S_BUSY;
        default: state <= S_WAIT;
      endcase
    end
  end

  assign tx_ok = (state == S_OPEN);

  assign rise = rx_dv & ~rx_dv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_dv_q  <= 1'b0;
      seen     <= 1'b0;
      gap      <= '0;
      rx_short <= 1'b0;
    end else begin
      rx_dv_q  <= rx_dv;
      rx_short <= rise && seen && (gap < RW'(RX_GAP_BT));
      if (rx_dv) begin
        gap  <= '0;
        seen <= 1'b1;
      end else if (bit_tick && gap != RW'(RX_GAP_BT)) begin
        gap <= gap + 1'b1;
      end
    end
  end
endmodule

module deferral_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic tx_done,
  input logic tx_start,
  input logic rx_dv,
  input logic tx_ok,
  input logic rx_short
);
  // R6
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ok && tx_start && !tx_done |=> !tx_ok);
  // R6
  ok_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ok && !tx_start && !tx_done |=> tx_ok);
  // R2
  done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_ok);
  // R7
  open_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ok) |-> $past(bit_tick));
  // R8
  short_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_short |=> !rx_short);
  // R8
  short_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_short |-> $past(rx_dv) && !$past(rx_dv, 2));
endmodule

bind deferral_timer deferral_timer_chk u_chk (.*);

// File: tb/sim_deferral_timer.sv
module sim_deferral_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0, crs = 1'b0, tx_done = 1'b0, tx_start = 1'b0, rx_dv = 1'b0;
  logic tx_ok, rx_short;
  int checks = 0, errors = 0, cyc = 0;

  deferral_timer u0 (.*);

  always #10 clk = ~clk;

  task automatic done_all();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      done_all();
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick();
    bit_tick = 1'b1; @(negedge clk);
    bit_tick = 1'b0; @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic restart();
    tx_done = 1'b1; @(negedge clk);
    tx_done = 1'b0;
    chk("R2 done clears", tx_ok, 1'b0);
    idle(2);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 reset tx_ok", tx_ok, 1'b0);
    chk("R1 reset rx_short", rx_short, 1'b0);
    rst_n = 1'b1;
    idle(2);
    for (int i = 1; i <= 100; i++) begin
      tick();
      chk("R1 R3 quiet deferral", tx_ok, logic'(i >= 96));
      if (i == 95) begin
        idle(30);
        chk("R7 no tick no progress", tx_ok, 1'b0);
      end
    end

    // R6: hold, then start
    crs = 1'b1; ticks(5); crs = 1'b0; idle(10);
    chk("R6 held while idle", tx_ok, 1'b1);
    tx_start = 1'b1; @(negedge clk); tx_start = 1'b0;
    chk("R6 start clears", tx_ok, 1'b0);
    ticks(120);
    chk("R6 stays low until done", tx_ok, 1'b0);

    // R2: carrier high after done
    crs = 1'b1;
    restart();
    ticks(100);
    chk("R2 no count while crs high", tx_ok, 1'b0);
    crs = 1'b0; idle(2);
    ticks(95);
    chk("R2 95 ticks after crs low", tx_ok, 1'b0);
    tick();
    chk("R2 96 ticks after crs low", tx_ok, 1'b1);

    // R4: carrier in early window at every position
    for (int k = 0; k < 60; k++) begin
      restart();
      ticks(k);
      crs = 1'b1; ticks(3);
      chk("R4 crs in early window", tx_ok, 1'b0);
      crs = 1'b0; idle(2);
      ticks(95);
      chk("R4 restarted count at 95", tx_ok, 1'b0);
      tick();
      chk("R4 restarted count at 96", tx_ok, 1'b1);
    end

    // R5: carrier in late window at every position
    for (int k = 60; k < 96; k++) begin
      restart();
      ticks(k);
      crs = 1'b1;
      ticks(95 - k);
      chk("R5 late crs before release", tx_ok, 1'b0);
      tick();
      chk("R5 late crs ignored", tx_ok, 1'b1);
      crs = 1'b0;
    end

    // R8 R9: receive gap sweep
    rx_dv = 1'b1; @(negedge clk);
    chk("R9 first frame not flagged", rx_short, 1'b0);
    idle(2); rx_dv = 1'b0; @(negedge clk);
    for (int n = 0; n <= 40; n++) begin
      ticks(n);
      rx_dv = 1'b1; @(negedge clk);
      chk(n < 28 ? "R8 short gap flagged" : "R9 long gap not flagged",
          rx_short, logic'(n < 28));
      @(negedge clk);
      chk("R8 single cycle pulse", rx_short, 1'b0);
      idle(2); rx_dv = 1'b0; @(negedge clk);
    end
    idle(10);
    chk("R8 idle after gap sweep", rx_short, 1'b0);
    done_all();
  end
endmodule